// File: doc/BRIEF.md
# Binary FSK Tone Generator

This block produces a stream of signed digital sine samples that carry 1200 bit/s binary frequency-shift keyed data. It runs from a 3.579545 MHz system clock. A 32-bit phase accumulator advances by one of two fixed steps on every clock, and the upper bits of the phase address a sine table that is built when the design is elaborated. A two-bit mode input selects one of three states: transmit, transmitter off, or zero-power. In transmit mode a single data bit picks the tone.

The tone changes only through its phase step. The phase is never reset while the block transmits, so a change of data bit gives a continuous waveform. In off mode the sample stream rests at zero, which is mid-scale. Zero-power mode also clears the phase, the output and the settling counter. When the block leaves zero-power, a counter times a 20 ms settling window. The settled flag goes high only after that window expires, and software uses the flag to decide when data may be sent. Reset puts the block in the same state as zero-power. The analog reconstruction filter, the line driver and the oscillator are outside this block.

Top module: `fsk_tone_gen`

## Requirements
- R1: The mode code is written `{mode_i[1], mode_i[0]}`. Code 01 means transmit, 10 means off and 11 means zero-power. Code 00 behaves exactly like off.
- R2: In transmit mode, on each clock the phase grows by round(f·2^32/CLK_HZ). Here f is 1300 Hz when `tx_bit_i` is 1 and 2100 Hz when `tx_bit_i` is 0. The frequency resolution is about 0.001 Hz, well inside the ±3 Hz tolerance.
- R3: A change of `tx_bit_i` during transmit changes only the phase step. The phase keeps its value across the change, so the samples that follow continue from the same point on the wave.
- R4: During transmit, `sample_o` after a clock edge equals round(127·sin(2π·k/256)), where k is bits 31:24 of the phase held before that edge.
- R5: At any edge that samples a mode other than transmit, `sample_o` becomes 0 and the phase is cleared. The first transmit sample after that is therefore 0, and the second is the table value at the top byte of one step.
- R6: The settling length is SETTLE_CYCLES = ceil(CLK_HZ·SETTLE_US/10^6), which is 71591 by default. The edge that first samples a non-zero-power mode counts as edge 1. `settled_o` goes high at edge SETTLE_CYCLES and not before.
- R7: `settled_o` goes low at the edge that samples zero-power, and the settling count starts again from zero. Moving between transmit and off leaves the count and the flag unchanged.
- R8: Reset (low `rst_n`, asynchronous) drives `sample_o` to 0 and `settled_o` to 0, and clears the phase. The block then behaves as if it had been in zero-power.
- R9: If zero-power is sampled at the same edge that would complete the settling window, zero-power takes priority: `settled_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (3.579545 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode code (see R1) |
| tx_bit_i | input | 1 | Data bit that selects the tone in transmit mode |
| sample_o | output | 8 | Signed sine sample, two's complement |
| settled_o | output | 1 | High once the settling window after zero-power has expired |

## Verification
Two actions can fall on the same clock edge: the settling counter completing its window and a request to enter zero-power. The bench holds transmit for exactly SETTLE_CYCLES−1 edges and then presents zero-power on the edge that would finish the window. It expects `settled_o` to stay low and the count to start again. A second collision is a data-bit change on the edge that enters transmit. A reference model of phase and counter judges that case, because the phase must start from zero and use the new step at once. A shortened settling parameter keeps the run brief.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

    typedef enum logic [1:0] {
        MODE_RSVD  = 2'b00,
        MODE_TX    = 2'b01,
        MODE_OFF   = 2'b10,
        MODE_SLEEP = 2'b11
    } fsk_mode_e;

    // Phase step for tone f_hz with an acc_w-bit accumulator, rounded to nearest
    function automatic longint unsigned tone_step(input longint unsigned f_hz,
                                                  input longint unsigned clk_hz,
                                                  input int unsigned     acc_w);
        return ((f_hz << acc_w) + clk_hz / 2) / clk_hz;
    endfunction

    // sin(pi/2 * q / qmax) scaled by 2^30, by a fixed-point Taylor series
    function automatic longint fx_quarter_sin(input int q, input int qmax);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (longint'(q) * 64'sd1686629713) / longint'(qmax);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int n = 1; n <= 7; n++) begin
            term = (-((term * x2) >>> 30)) / (longint'(2 * n) * longint'(2 * n + 1));
            sum  = sum + term;
        end
        return sum;
    endfunction

    // Table entry idx of a full sine period with 2^aw entries and sw-bit samples
    function automatic int sine_code(input int idx, input int aw, input int sw);
        int     quarter;
        int     amp;
        int     r;
        int     quad;
        int     q;
        longint v;
        quarter = 1 << (aw - 2);
        amp     = (1 << (sw - 1)) - 1;
        r       = idx % quarter;
        quad    = (idx / quarter) % 4;
        q       = (quad % 2 == 1) ? (quarter - r) : r;
        v       = (fx_quarter_sin(q, quarter) * longint'(amp) + (longint'(1) << 29)) >>> 30;
        return (quad >= 2) ? -int'(v) : int'(v);
    endfunction

endpackage

// File: rtl/fsk_mode_decode.sv
module fsk_mode_decode
    import fsk_tone_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       tx_en_o,
    output logic       sleep_o
);

    fsk_mode_e mode;

    always_comb begin
        mode    = fsk_mode_e'(mode_i);
        tx_en_o = 1'b0;
        sleep_o = 1'b0;
        unique case (mode)
            MODE_TX:    tx_en_o = 1'b1;
            MODE_SLEEP: sleep_o = 1'b1;
            MODE_OFF,
            MODE_RSVD:  ;
            default:    ;
        endcase
    end

    always_comb begin
        assert (!(tx_en_o && sleep_o)) else $error("AST_MODE_EXCLUSIVE");  // R1
    end

endmodule

// File: rtl/fsk_phase_accum.sv
module fsk_phase_accum #(
    parameter int              ACC_W      = 32,
    parameter int              IDX_W      = 8,
    parameter logic [ACC_W-1:0] MARK_STEP  = '0,
    parameter logic [ACC_W-1:0] SPACE_STEP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en_i,
    input  logic             mark_i,
    output logic [IDX_W-1:0] index_o
);

    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_en_i) begin
            st_d.phase = st_q.phase + (mark_i ? MARK_STEP : SPACE_STEP);
        end else begin
            st_d.phase = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign index_o = st_q.phase[ACC_W-1 -: IDX_W];

    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> (st_q.phase == '0)) else $error("AST_PHASE_CLEARED");  // R5

    AST_MARK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_i && mark_i) |=> ((st_q.phase - $past(st_q.phase)) == MARK_STEP))
        else $error("AST_MARK_STEP");  // R2

    AST_SPACE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_i && !mark_i) |=> ((st_q.phase - $past(st_q.phase)) == SPACE_STEP))
        else $error("AST_SPACE_STEP");  // R3

endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]        addr_i,
    output logic signed [DATA_W-1:0] data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic signed [DATA_W-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam logic signed [DATA_W-1:0] VAL =
            DATA_W'(fsk_tone_pkg::sine_code(k, ADDR_W, DATA_W));
        assign table_w[k] = VAL;
    end

    assign data_o = table_w[addr_i];

endmodule

// File: rtl/fsk_settle_timer.sv
module fsk_settle_timer #(
    parameter int SETTLE_CYCLES = 71591
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic settled_o
);

    localparam int              CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sleep_i) begin
            st_d.count = '0;
        end else if (st_q.count != LIMIT) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign settled_o = (st_q.count == LIMIT);

    AST_SLEEP_DROPS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !settled_o) else $error("AST_SLEEP_DROPS_SETTLED");  // R7

    AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_o && !sleep_i) |=> settled_o) else $error("AST_SETTLED_HOLDS");  // R6

    AST_SETTLED_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!settled_o && (st_q.count != LIMIT - 1'b1)) |=> !settled_o)
        else $error("AST_SETTLED_NOT_EARLY");  // R6

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
    parameter int CLK_HZ    = 3579545,
    parameter int MARK_HZ   = 1300,
    parameter int SPACE_HZ  = 2100,
    parameter int SETTLE_US = 20000,
    parameter int ACC_W     = 32,
    parameter int LUT_AW    = 8,
    parameter int SAMP_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              tx_bit_i,
    output logic [SAMP_W-1:0] sample_o,
    output logic              settled_o
);

    localparam logic [ACC_W-1:0] MARK_STEP =
        ACC_W'(fsk_tone_pkg::tone_step(longint'(MARK_HZ), longint'(CLK_HZ), ACC_W));
    localparam logic [ACC_W-1:0] SPACE_STEP =
        ACC_W'(fsk_tone_pkg::tone_step(longint'(SPACE_HZ), longint'(CLK_HZ), ACC_W));
    localparam int SETTLE_CYCLES =
        int'((longint'(CLK_HZ) * longint'(SETTLE_US) + 64'd999999) / 64'd1000000);

    typedef struct packed {
        logic signed [SAMP_W-1:0] sample;
    } out_state_t;

    logic                     tx_en;
    logic                     sleep;
    logic [LUT_AW-1:0]        lut_addr;
    logic signed [SAMP_W-1:0] lut_val;
    out_state_t               st_d, st_q;

    fsk_mode_decode u_decode (
        .mode_i  (mode_i),
        .tx_en_o (tx_en),
        .sleep_o (sleep)
    );

    fsk_phase_accum #(
        .ACC_W      (ACC_W),
        .IDX_W      (LUT_AW),
        .MARK_STEP  (MARK_STEP),
        .SPACE_STEP (SPACE_STEP)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en_i (tx_en),
        .mark_i  (tx_bit_i),
        .index_o (lut_addr)
    );

    fsk_sine_lut #(
        .ADDR_W (LUT_AW),
        .DATA_W (SAMP_W)
    ) u_lut (
        .addr_i (lut_addr),
        .data_o (lut_val)
    );

    fsk_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_i   (sleep),
        .settled_o (settled_o)
    );

    always_comb begin
        st_d = st_q;
        st_d.sample = tx_en ? lut_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.sample;

    AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b01) |=> (sample_o == '0)) else $error("AST_SILENT_WHEN_IDLE");  // R5

    AST_FIRST_TX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b01) && ($past(mode_i) != 2'b01)) |=> (sample_o == '0))
        else $error("AST_FIRST_TX_ZERO");  // R5

endmodule

// File: tb/fsk_tone_gen_tb.sv
module fsk_tone_gen_tb;

    localparam int  CLK_HZ    = 3579545;
    localparam int  SETTLE_US = 20;
    localparam int  N_SETTLE  = int'((longint'(CLK_HZ) * SETTLE_US + 999999) / 1000000);
    localparam longint unsigned MARK_INC  = ((64'd1300 << 32) + CLK_HZ / 2) / CLK_HZ;
    localparam longint unsigned SPACE_INC = ((64'd2100 << 32) + CLK_HZ / 2) / CLK_HZ;

    // columns: mode code, data bit, cycles
    localparam int NVEC = 11;
    localparam int VEC [NVEC][3] = '{
        '{3, 0, 4},  '{2, 1, 4},  '{1, 1, 30}, '{1, 0, 30}, '{1, 1, 1}, '{1, 0, 1},
        '{1, 1, 1},  '{0, 1, 5},  '{1, 0, 12}, '{2, 0, 3},  '{1, 1, 8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b11;
    logic       txb = 1'b0;
    logic [7:0] sample;
    logic       settled;

    int checks = 0;
    int errors = 0;
    logic [31:0] ph = '0;
    int cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fsk_tone_gen #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .tx_bit_i  (txb),
        .sample_o  (sample),
        .settled_o (settled)
    );

    function automatic int lut_ref(input int k);
        real v;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 256.0);
        return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    endfunction

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ph  = '0;
        cnt = 0;
    endtask

    // Drive at the falling edge, model the rising edge, compare at the next falling edge
    task automatic step(input logic [1:0] m, input logic d, input string tag);
        bit tx;
        int exp_s;
        int act_s;
        mode = m;
        txb  = d;
        @(posedge clk);
        tx    = (m == 2'b01);
        exp_s = tx ? lut_ref(int'(ph[31:24])) : 0;
        ph    = tx ? ph + 32'(d ? MARK_INC : SPACE_INC) : 32'd0;
        cnt   = (m == 2'b11) ? 0 : ((cnt == N_SETTLE) ? N_SETTLE : cnt + 1);
        @(negedge clk);
        act_s = int'($signed(sample));
        if (tx) chk(tag, (act_s - exp_s <= 1) && (exp_s - act_s <= 1), act_s, exp_s);
        else    chk(tag, act_s == 0, act_s, 0);
        chk("R6 R7 settled", settled == (cnt == N_SETTLE), int'(settled), int'(cnt == N_SETTLE));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mode  = 2'b11;
        #1;
        chk("R8 sample in reset", sample == 8'd0, int'($signed(sample)), 0);
        chk("R8 settled in reset", settled == 1'b0, int'(settled), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: modes, tones, toggles, reserved code
        for (int i = 0; i < NVEC; i++) begin
            for (int c = 0; c < VEC[i][2]; c++) begin
                case (VEC[i][0])
                    1:       step(2'b01, VEC[i][1] != 0, "R2 R3 R4 tx");
                    2:       step(2'b10, VEC[i][1] != 0, "R5 off");
                    3:       step(2'b11, VEC[i][1] != 0, "R5 sleep");
                    default: step(2'b00, VEC[i][1] != 0, "R1 code00");
                endcase
            end
        end

        // R5: after off, first tx sample 0, second from one mark step
        step(2'b10, 1'b0, "R5 off");
        step(2'b01, 1'b1, "R5 first tx");
        chk("R5 restart zero", sample == 8'd0, int'($signed(sample)), 0);
        step(2'b01, 1'b0, "R5 second tx");
        chk("R5 second sample", (int'($signed(sample)) - lut_ref(int'(MARK_INC >> 24)) <= 1) &&
            (lut_ref(int'(MARK_INC >> 24)) - int'($signed(sample)) <= 1),
            int'($signed(sample)), lut_ref(int'(MARK_INC >> 24)));

        // R6: exact settle edge from zero-power, with independent edge count
        step(2'b11, 1'b0, "R7 sleep");
        chk("R7 settled drops", settled == 1'b0, int'(settled), 0);
        for (int e = 1; e < N_SETTLE; e++) step(2'b01, e[0], "R3 tx");
        chk("R6 not yet settled", settled == 1'b0, int'(settled), 0);
        step(2'b10, 1'b0, "R5 off");
        chk("R6 settled at edge N", settled == 1'b1, int'(settled), 1);
        // R7: tx/off moves keep the flag
        step(2'b01, 1'b1, "R2 tx");
        step(2'b00, 1'b1, "R1 code00");
        chk("R7 flag kept", settled == 1'b1, int'(settled), 1);

        // R9: zero-power on the completing edge wins
        step(2'b11, 1'b0, "R7 sleep");
        for (int e = 1; e < N_SETTLE; e++) step(2'b01, 1'b0, "R2 tx");
        step(2'b11, 1'b1, "R9 collide");
        chk("R9 sleep wins", settled == 1'b0, int'(settled), 0);
        step(2'b01, 1'b1, "R9 restart");
        chk("R9 count restarted", settled == 1'b0, int'(settled), 0);

        // R8: reset in the middle of a transmission
        for (int e = 0; e < 10; e++) step(2'b01, 1'b1, "R4 tx");
        do_reset();
        step(2'b01, 1'b0, "R8 after reset");
        chk("R8 phase cleared", sample == 8'd0, int'($signed(sample)), 0);
        step(2'b01, 1'b0, "R8 tx");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule